// File: doc/BRIEF.md
# Timed SPI Master Frame Sequencer

This block is an SPI master that runs one command frame at a time to a single sensor-style slave. It guarantees a set of minimum interface timings on its own. A host presents a command byte, an optional write byte, a length select and a one-cycle start strobe. The block lowers chip select, clocks out the command (and the write byte when the long frame is selected) most-significant bit first, and captures the slave's reply at the same time. It then raises chip select and gives back the received word with a one-cycle done pulse.

Every timing is a clock-cycle count worked out at elaboration from the system clock frequency and a nanosecond parameter. The rounding is upward, with a floor of one cycle. The timings are: chip-select lead before the first clock rise, lag after the last clock fall, clock high time, clock low time, and the minimum chip-select-high gap between frames. The gap is short by default. It becomes the long value when the frame's command byte matches an entry in a parameterised list, such as commands that read axis data or write a register and trigger. A start that arrives during the gap is held and launched exactly when the gap ends. Busy stays high the whole time.

Top module: `spi_seq_master`

## Requirements
- R1: While reset is asserted and after its release, csb_o is 1, sck_o is 0, busy_o is 0 and done_o is 0 until a start is accepted.
- R2: A start_i sampled high while busy_o is 0 pulls csb_o low and raises busy_o on the next clock edge.
- R3: The first rising edge of sck_o comes exactly max(ceil(LEAD_NS), ceil(SCK_LO_NS)) clock cycles after csb_o falls, where ceil(x) = max(1, ceil(x * CLK_HZ / 1e9)).
- R4: sck_o stays high exactly ceil(SCK_HI_NS) cycles and low exactly ceil(SCK_LO_NS) cycles between pulses. sck_o is 0 whenever csb_o is 1 (mode 0, clock idles low).
- R5: On mosi_o the command byte goes out, followed (when wide_i=1) by the write byte, each bit most-significant first and sampled by the slave on sck_o rising edges. While csb_o is low, mosi_o changes only in the cycle where sck_o falls or csb_o falls.
- R6: miso_i is captured on each sck_o rising edge, most-significant first. For a 16-bit frame, rdata_o holds all 16 bits. For an 8-bit frame, rdata_o[7:0] holds them and rdata_o[15:8] is 0.
- R7: A frame has 8 sck_o pulses when wide_i=0 and 16 when wide_i=1.
- R8: csb_o rises exactly ceil(LAG_NS) cycles after the last sck_o falling edge.
- R9: done_o is a single-cycle pulse, high in the same cycle in which csb_o returns high.
- R10: After a frame, csb_o stays high for ceil(SHORT_GAP_NS) cycles. If the frame's command byte equals any entry of LONG_CMDS, it stays high for ceil(LONG_GAP_NS) cycles instead.
- R11: A start_i accepted while csb_o is high in the gap is held. The next frame's csb_o fall comes exactly when the gap ends, and busy_o stays 1 throughout.
- R12: A start_i pulse while csb_o is low has no effect: no further frame follows the gap.
- R13: With no request held, busy_o drops exactly the gap length in cycles after the done_o cycle. busy_o is 1 whenever csb_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to run a frame |
| cmd_i | input | CMD_W (8) | Command byte, sent first |
| wdata_i | input | DATA_W (8) | Write byte, sent second in a long frame |
| wide_i | input | 1 | 0: 8-bit frame, 1: 16-bit frame |
| rdata_o | output | CMD_W+DATA_W (16) | Bits shifted in from the slave, right aligned |
| busy_o | output | 1 | Frame, gap or held request in progress |
| done_o | output | 1 | One-cycle pulse as chip select rises |
| csb_o | output | 1 | Active-low chip select |
| sck_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the slave |
| miso_i | input | 1 | Serial data from the slave |

## Verification
The hardest case to reach is a request that lands inside the inter-frame gap. If the bench waits for busy to drop before issuing the next start, the held-request path is never taken and the gap length cannot be measured to the cycle. The bench therefore issues every following start in the cycle right after done. It then measures the chip-select-high interval to the next fall. It does this across all 256 command byte values, so each entry of the long-gap list and every near miss is seen on both the short and the long path. A start pulsed in the middle of a frame, followed by a quiet stretch after the gap, covers the ignored case.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_LAG,
    ST_GAP
  } seq_state_e;

  // Cycles needed to cover ns nanoseconds at clk_hz, rounded up, never zero.
  function automatic int unsigned ns_to_cycles(input longint unsigned ns,
                                               input longint unsigned clk_hz);
    longint unsigned prod;
    longint unsigned cyc;
    prod = ns * clk_hz;
    cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
    if (cyc == 64'd0) cyc = 64'd1;
    return 32'(cyc);
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/spi_seq_timer.sv
module spi_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/spi_seq_shift.sv
module spi_seq_shift #(
  parameter int CMD_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic [CMD_W-1:0]        cmd_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic                    wide_i,
  input  logic                    rise_i,
  input  logic                    fall_i,
  input  logic                    miso_i,
  output logic                    mosi_o,
  output logic [CMD_W+DATA_W-1:0] rdata_o,
  output logic                    last_o
);

  localparam int FRAME_W = CMD_W + DATA_W;
  localparam int BCNT_W  = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] tx_q, tx_d;
  logic [FRAME_W-1:0] rx_q, rx_d;
  logic [BCNT_W-1:0]  bits_q, bits_d;
  logic               wide_q, wide_d;
  logic               sh_en;
  logic [BCNT_W-1:0]  bits_target;

  assign sh_en = load_i || rise_i || fall_i;

  always_comb begin
    tx_d   = tx_q;
    rx_d   = rx_q;
    bits_d = bits_q;
    wide_d = wide_q;
    if (load_i) begin
      tx_d   = {cmd_i, wdata_i};
      rx_d   = '0;
      bits_d = '0;
      wide_d = wide_i;
    end else begin
      if (rise_i) begin
        rx_d   = {rx_q[FRAME_W-2:0], miso_i};
        bits_d = bits_q + 1'b1;
      end
      if (fall_i) begin
        tx_d = {tx_q[FRAME_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      bits_q <= '0;
      wide_q <= 1'b0;
    end else if (sh_en) begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      bits_q <= bits_d;
      wide_q <= wide_d;
    end
  end

  assign bits_target = wide_q ? BCNT_W'(FRAME_W) : BCNT_W'(CMD_W);
  assign last_o      = (bits_q == bits_target);
  assign mosi_o      = tx_q[FRAME_W-1];
  assign rdata_o     = rx_q;

endmodule

// File: rtl/spi_seq_gapsel.sv
module spi_seq_gapsel #(
  parameter int                   CMD_W     = 8,
  parameter int                   N_LONG    = 3,
  parameter logic [N_LONG*CMD_W-1:0] LONG_CMDS = '0
) (
  input  logic [CMD_W-1:0] cmd_i,
  output logic             long_o
);

  logic [N_LONG-1:0] hit;

  for (genvar i = 0; i < N_LONG; i++) begin : g_match
    assign hit[i] = (cmd_i == LONG_CMDS[i*CMD_W +: CMD_W]);
  end

  assign long_o = |hit;

endmodule

// File: rtl/spi_seq_master.sv
module spi_seq_master
  import spi_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 200_000_000,
  parameter int unsigned LEAD_NS      = 120,
  parameter int unsigned LAG_NS       = 120,
  parameter int unsigned SCK_HI_NS    = 1000,
  parameter int unsigned SCK_LO_NS    = 1000,
  parameter int unsigned SHORT_GAP_NS = 15_000,
  parameter int unsigned LONG_GAP_NS  = 150_000,
  parameter int          CMD_W        = 8,
  parameter int          DATA_W       = 8,
  parameter int          N_LONG       = 3,
  parameter logic [N_LONG*CMD_W-1:0] LONG_CMDS = {8'h10, 8'h11, 8'h08},
  localparam int         FRAME_W      = CMD_W + DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [CMD_W-1:0]   cmd_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               wide_i,
  output logic [FRAME_W-1:0] rdata_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               csb_o,
  output logic               sck_o,
  output logic               mosi_o,
  input  logic               miso_i
);

  localparam int unsigned LEAD_CYC  = ns_to_cycles(LEAD_NS, CLK_HZ);
  localparam int unsigned LAG_CYC   = ns_to_cycles(LAG_NS, CLK_HZ);
  localparam int unsigned HI_CYC    = ns_to_cycles(SCK_HI_NS, CLK_HZ);
  localparam int unsigned LO_CYC    = ns_to_cycles(SCK_LO_NS, CLK_HZ);
  localparam int unsigned SGAP_CYC  = ns_to_cycles(SHORT_GAP_NS, CLK_HZ);
  localparam int unsigned LGAP_CYC  = ns_to_cycles(LONG_GAP_NS, CLK_HZ);
  localparam int unsigned LEAD_PH   = max_u(LEAD_CYC, LO_CYC);
  localparam int unsigned MAX_CYC   = max_u(max_u(max_u(LEAD_PH, LAG_CYC), max_u(HI_CYC, LO_CYC)),
                                            max_u(SGAP_CYC, LGAP_CYC));
  localparam int          CNT_W     = $clog2(MAX_CYC + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rsync_q[1];

  seq_state_e         state_q, state_d;
  logic               tmr_load;
  logic [CNT_W-1:0]   tmr_val;
  logic               tmr_expired;
  logic               sh_load, sh_rise, sh_fall, sh_last;
  logic               pend_q, pend_d;
  logic               req_cap;
  logic [CMD_W-1:0]   req_cmd_q;
  logic [DATA_W-1:0]  req_wdata_q;
  logic               req_wide_q;
  logic [CMD_W-1:0]   launch_cmd;
  logic [DATA_W-1:0]  launch_wdata;
  logic               launch_wide;
  logic               launch_long;
  logic               gap_long_q, gap_long_d;
  logic               csb_q, csb_d;
  logic               sck_q, sck_d;
  logic               busy_q, busy_d;
  logic               done_q, done_d;

  // held request wins over fresh inputs
  assign launch_cmd   = pend_q ? req_cmd_q   : cmd_i;
  assign launch_wdata = pend_q ? req_wdata_q : wdata_i;
  assign launch_wide  = pend_q ? req_wide_q  : wide_i;

  spi_seq_gapsel #(
    .CMD_W    (CMD_W),
    .N_LONG   (N_LONG),
    .LONG_CMDS(LONG_CMDS)
  ) u_gapsel (
    .cmd_i (launch_cmd),
    .long_o(launch_long)
  );

  spi_seq_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .expired_o (tmr_expired)
  );

  spi_seq_shift #(
    .CMD_W (CMD_W),
    .DATA_W(DATA_W)
  ) u_shift (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (sh_load),
    .cmd_i  (launch_cmd),
    .wdata_i(launch_wdata),
    .wide_i (launch_wide),
    .rise_i (sh_rise),
    .fall_i (sh_fall),
    .miso_i (miso_i),
    .mosi_o (mosi_o),
    .rdata_o(rdata_o),
    .last_o (sh_last)
  );

  // next-state logic
  always_comb begin
    state_d    = state_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    sh_load    = 1'b0;
    sh_rise    = 1'b0;
    sh_fall    = 1'b0;
    pend_d     = pend_q;
    req_cap    = 1'b0;
    gap_long_d = gap_long_q;
    done_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d    = ST_LEAD;
          tmr_load   = 1'b1;
          tmr_val    = CNT_W'(LEAD_PH - 1);
          sh_load    = 1'b1;
          gap_long_d = launch_long;
        end
      end
      ST_LEAD: begin
        if (tmr_expired) begin
          state_d  = ST_HIGH;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(HI_CYC - 1);
          sh_rise  = 1'b1;
        end
      end
      ST_HIGH: begin
        if (tmr_expired) begin
          sh_fall  = 1'b1;
          tmr_load = 1'b1;
          if (sh_last) begin
            state_d = ST_LAG;
            tmr_val = CNT_W'(LAG_CYC - 1);
          end else begin
            state_d = ST_LOW;
            tmr_val = CNT_W'(LO_CYC - 1);
          end
        end
      end
      ST_LOW: begin
        if (tmr_expired) begin
          state_d  = ST_HIGH;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(HI_CYC - 1);
          sh_rise  = 1'b1;
        end
      end
      ST_LAG: begin
        if (tmr_expired) begin
          state_d  = ST_GAP;
          tmr_load = 1'b1;
          tmr_val  = gap_long_q ? CNT_W'(LGAP_CYC - 1) : CNT_W'(SGAP_CYC - 1);
          done_d   = 1'b1;
        end
      end
      ST_GAP: begin
        if (tmr_expired) begin
          if (pend_q || start_i) begin
            state_d    = ST_LEAD;
            tmr_load   = 1'b1;
            tmr_val    = CNT_W'(LEAD_PH - 1);
            sh_load    = 1'b1;
            gap_long_d = launch_long;
            pend_d     = 1'b0;
          end else begin
            state_d = ST_IDLE;
          end
        end else if (start_i && !pend_q) begin
          pend_d  = 1'b1;
          req_cap = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    csb_d  = !(state_d inside {ST_LEAD, ST_HIGH, ST_LOW, ST_LAG});
    sck_d  = (state_d == ST_HIGH);
    busy_d = (state_d != ST_IDLE);
  end

  // register process
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q    <= ST_IDLE;
      pend_q     <= 1'b0;
      gap_long_q <= 1'b0;
      csb_q      <= 1'b1;
      sck_q      <= 1'b0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      pend_q     <= pend_d;
      gap_long_q <= gap_long_d;
      csb_q      <= csb_d;
      sck_q      <= sck_d;
      busy_q     <= busy_d;
      done_q     <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      req_cmd_q   <= '0;
      req_wdata_q <= '0;
      req_wide_q  <= 1'b0;
    end else if (req_cap) begin
      req_cmd_q   <= cmd_i;
      req_wdata_q <= wdata_i;
      req_wide_q  <= wide_i;
    end
  end

  assign csb_o  = csb_q;
  assign sck_o  = sck_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

endmodule

// File: rtl/spi_seq_master_chk.sv
module spi_seq_master_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic csb_o,
  input logic sck_o,
  input logic mosi_o
);

  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csb_o |-> !sck_o);

  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!csb_o && $past(!csb_o) && !$fell(sck_o)) |-> $stable(mosi_o));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (csb_o && $past(!csb_o)));

  // R13
  busy_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csb_o |-> busy_o);

  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (!csb_o && busy_o));

endmodule

bind spi_seq_master spi_seq_master_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_int_n),
  .start_i(start_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .csb_o  (csb_o),
  .sck_o  (sck_o),
  .mosi_o (mosi_o)
);

// File: tb/spi_seq_master_tb_top.sv
`timescale 1ns/1ps
module spi_seq_master_tb_top;

  localparam int unsigned CLK_HZ = 200_000_000;
  localparam int unsigned LEAD_NS = 120;
  localparam int unsigned LAG_NS  = 90;
  localparam int unsigned HI_NS   = 33;
  localparam int unsigned LO_NS   = 40;
  localparam int unsigned SG_NS   = 200;
  localparam int unsigned LG_NS   = 2000;
  localparam logic [23:0] LCMDS   = {8'h10, 8'h11, 8'h08};

  // expected cycle counts at 5 ns per cycle, rounded up, at least one
  function automatic int cyc_of(input int ns);
    int c;
    c = (ns + 4) / 5;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int E_LEAD = (cyc_of(LEAD_NS) > cyc_of(LO_NS)) ? cyc_of(LEAD_NS) : cyc_of(LO_NS);
  localparam int E_LAG  = cyc_of(LAG_NS);
  localparam int E_HI   = cyc_of(HI_NS);
  localparam int E_LO   = cyc_of(LO_NS);
  localparam int E_SG   = cyc_of(SG_NS);
  localparam int E_LG   = cyc_of(LG_NS);

  function automatic int gap_of(input logic [7:0] c);
    return (c == 8'h10 || c == 8'h11 || c == 8'h08) ? E_LG : E_SG;
  endfunction

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [7:0]  cmd_i;
  logic [7:0]  wdata_i;
  logic        wide_i;
  logic [15:0] rdata_o;
  logic        busy_o, done_o, csb_o, sck_o, mosi_o;
  logic        miso_i;

  spi_seq_master #(
    .CLK_HZ(CLK_HZ), .LEAD_NS(LEAD_NS), .LAG_NS(LAG_NS),
    .SCK_HI_NS(HI_NS), .SCK_LO_NS(LO_NS),
    .SHORT_GAP_NS(SG_NS), .LONG_GAP_NS(LG_NS),
    .CMD_W(8), .DATA_W(8), .N_LONG(3), .LONG_CMDS(LCMDS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
    .wdata_i(wdata_i), .wide_i(wide_i), .rdata_o(rdata_o),
    .busy_o(busy_o), .done_o(done_o), .csb_o(csb_o), .sck_o(sck_o),
    .mosi_o(mosi_o), .miso_i(miso_i)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // slave: presents the next bit after chip select falls and after each clock fall
  logic [15:0] slv_pat;
  int          slv_idx = -1;
  always @(csb_o or negedge sck_o) begin
    if (csb_o) slv_idx = -1;
    else begin
      slv_idx = slv_idx + 1;
      if (slv_idx >= 0 && slv_idx < 16) miso_i = slv_pat[15 - slv_idx];
    end
  end

  // line monitor, sampled on falling clock edges
  int          cyc = 0;
  logic        pcsb = 1'b1, psck = 1'b0, pmosi = 1'b0;
  int          fall_cyc, rise_cyc, sck_r_cyc, sck_f_cyc;
  bit          have_rise = 0;
  int          last_gap, lead_m, lag_m, nrise;
  int          hi_bad, lo_bad, mosi_bad;
  logic [15:0] mon_bits;

  always @(negedge clk) begin
    cyc++;
    if (pcsb && !csb_o) begin
      if (have_rise) last_gap = cyc - rise_cyc;
      fall_cyc = cyc; nrise = 0; mon_bits = '0;
      hi_bad = 0; lo_bad = 0; mosi_bad = 0;
    end
    if (!psck && sck_o) begin
      if (nrise == 0) lead_m = cyc - fall_cyc;
      else if (cyc - sck_f_cyc != E_LO) lo_bad++;
      mon_bits = {mon_bits[14:0], mosi_o};
      nrise++;
      sck_r_cyc = cyc;
    end
    if (psck && !sck_o) begin
      if (cyc - sck_r_cyc != E_HI) hi_bad++;
      sck_f_cyc = cyc;
    end
    if (!pcsb && csb_o) begin
      lag_m = cyc - sck_f_cyc; rise_cyc = cyc; have_rise = 1;
    end
    if (!csb_o && !pcsb && (mosi_o !== pmosi) && !(psck && !sck_o)) mosi_bad++;
    pcsb = csb_o; psck = sck_o; pmosi = mosi_o;
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  int done_cyc;

  task automatic run_frame(input logic [7:0] c, input logic [7:0] w, input logic wide,
                           input logic [15:0] pat, input bit chained, input int gap_exp);
    int lowbusy;
    logic [15:0] e_tx, e_rx;
    slv_pat = pat; cmd_i = c; wdata_i = w; wide_i = wide; start_i = 1'b1;
    tick();
    start_i = 1'b0;
    if (!chained) chk(csb_o == 1'b0 && busy_o == 1'b1, "R2 launch", {csb_o, busy_o}, 1);
    lowbusy = 0;
    while (!done_o) begin
      if (!busy_o) lowbusy++;
      tick();
    end
    done_cyc = cyc;
    e_tx = wide ? {c, w} : {8'h00, c};
    e_rx = wide ? pat : {8'h00, pat[15:8]};
    chk(nrise == (wide ? 16 : 8), "R7 pulse count", nrise, wide ? 16 : 8);
    chk(mon_bits == e_tx, "R5 mosi bits", mon_bits, e_tx);
    chk(mosi_bad == 0, "R5 mosi change", mosi_bad, 0);
    chk(rdata_o == e_rx, "R6 rdata", rdata_o, e_rx);
    chk(lead_m == E_LEAD, "R3 lead", lead_m, E_LEAD);
    chk(hi_bad == 0 && lo_bad == 0, "R4 sck phases", hi_bad + lo_bad, 0);
    chk(lag_m == E_LAG, "R8 lag", lag_m, E_LAG);
    chk(csb_o == 1'b1, "R9 done with csb", csb_o, 1);
    if (chained) begin
      chk(last_gap == gap_exp, "R10 gap", last_gap, gap_exp);
      chk(lowbusy == 0, "R11 busy held", lowbusy, 0);
    end
    tick();
    chk(done_o == 1'b0, "R9 done width", done_o, 0);
  endtask

  task automatic wait_idle(input int gap_exp);
    while (busy_o) tick();
    chk(cyc - done_cyc == gap_exp, "R13 busy release", cyc - done_cyc, gap_exp);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200_000, 0);
    finish_run();
  end

  initial begin
    int prev_gap;
    int lows;
    rst_n = 1'b0; start_i = 1'b0; cmd_i = '0; wdata_i = '0; wide_i = 1'b0;
    slv_pat = '0; miso_i = 1'b0;
    repeat (3) tick();
    chk(csb_o == 1'b1 && sck_o == 1'b0 && busy_o == 1'b0 && done_o == 1'b0,
        "R1 in reset", {csb_o, sck_o, busy_o, done_o}, 4'b1000);
    rst_n = 1'b1;
    repeat (5) tick();
    chk(csb_o == 1'b1 && sck_o == 1'b0 && busy_o == 1'b0 && done_o == 1'b0,
        "R1 after release", {csb_o, sck_o, busy_o, done_o}, 4'b1000);

    // every command byte, short frames, back to back through the gap
    prev_gap = 0;
    for (int c = 0; c < 256; c++) begin
      run_frame(8'(c), ~8'(c), 1'b0, {8'(c) ^ 8'hA5, 8'(c)}, c != 0, prev_gap);
      prev_gap = gap_of(8'(c));
    end

    // long frames, including list members, chained on
    for (int k = 0; k < 8; k++) begin
      logic [7:0] cc;
      case (k)
        0: cc = 8'h10; 1: cc = 8'h00; 2: cc = 8'h11; 3: cc = 8'hFF;
        4: cc = 8'h08; 5: cc = 8'h5A; 6: cc = 8'h09; default: cc = 8'h81;
      endcase
      run_frame(cc, 8'(k * 37 + 3), 1'b1, 16'(16'hC3A5 ^ (k * 16'h1111)), 1'b1, prev_gap);
      prev_gap = gap_of(cc);
    end
    wait_idle(prev_gap);

    // R12: start during a frame is ignored
    slv_pat = 16'h6E19; cmd_i = 8'h22; wdata_i = 8'h4D; wide_i = 1'b1; start_i = 1'b1;
    tick();
    start_i = 1'b0;
    repeat (60) tick();
    chk(csb_o == 1'b0, "R12 mid frame", csb_o, 0);
    cmd_i = 8'h10; start_i = 1'b1;
    tick();
    start_i = 1'b0;
    while (!done_o) tick();
    done_cyc = cyc;
    chk(rdata_o == 16'h6E19, "R6 rdata after ignored start", rdata_o, 16'h6E19);
    wait_idle(E_SG);
    lows = 0;
    for (int t = 0; t < 60; t++) begin
      if (!csb_o || busy_o) lows++;
      tick();
    end
    chk(lows == 0, "R12 no extra frame", lows, 0);

    // short frame from idle after quiet period
    run_frame(8'h08, 8'h00, 1'b0, 16'h8000, 1'b0, 0);
    wait_idle(E_LG);

    finish_run();
  end

endmodule